// File: doc/BRIEF.md
# Synchronous 8-bit serial shift port

This block is a memory-mapped shift unit for byte-wide synchronous serial links. Software loads a byte into the data register, sets the mode register and writes the start bit. The block then sends eight bits on the serial output while it captures eight bits from the serial input. When the last bit is in, it raises a completion flag that can drive an interrupt. The received byte is then read back from the same data register.

The shift clock comes from one of three internal divisions of the system clock, or from an external clock pin. When the source is internal, the block can drive that clock onto the pin. When the source is external, the block waits for edges on the pin. Bit order is applied as the data register is written and read, so the shifter itself always runs in one direction. Two enable outputs tell the surrounding pin multiplexer whether the clock pin and the data pin belong to this block.

Top module: `sio8_port`

## Requirements
- R1: Mode register (address 0) bits: 0 start/busy, 1 completion flag, 2 interrupt enable, 4:3 clock select, 5 order (1 = most significant bit first), 6 clock-pin drive enable, 7 data-pin enable. On the rising shift-clock edge that takes in the eighth bit, the flag reads 1 and the start/busy bit reads 0 from the next cycle on.
- R2: A mode write with bit 1 = 0 clears the completion flag. A mode write with bit 1 = 1 leaves the flag unchanged.
- R3: `irq` is 1 exactly when both the completion flag and the interrupt enable are 1.
- R4: Clock select codes 00, 01 and 10 give shift-clock periods of 2, 8 and 32 system clocks. Code 11 selects the external pin. The internal clock `sck_out` rests at 1 while no transfer runs. After the start write, it falls N/2 cycles later and then toggles every N/2 cycles.
- R5: `sck_oe` is 1 only when the clock-pin drive enable is 1 and the clock select is not 11.
- R6: `sdo` changes only on falling shift-clock edges. At each falling edge it takes the next bit in transfer order. `sdo_en` follows mode bit 7.
- R7: The data register (address 1) is reordered when it is written and again when it is read, using the order bit in force at that access. Changing the order bit does not reorder a byte that is already loaded. After a transfer, a read returns the received byte in the current order.
- R8: `sdi` is sampled on each rising shift-clock edge.
- R9: With code 11, a transfer does not advance until edges arrive on `sck_in`. An edge is acted on at the third system clock edge after `sck_in` changes.
- R10: A mode write with bit 0 = 0 during a transfer aborts it. Busy reads 0 and the flag stays clear.
- R11: If a write that clears the flag lands in the same cycle that the transfer completes, the flag is still set.
- R12: After reset the mode register reads 0x00, the data register reads 0x00, `sck_out` and `sdo` are 1, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mode, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sck_in | input | 1 | External shift clock from the pin |
| sck_out | output | 1 | Internal shift clock toward the pin |
| sck_oe | output | 1 | Block drives the clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Data pin belongs to the block |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag-clearing register write that lands on the exact system clock edge where the eighth input bit arrives. The bench starts a fastest-rate transfer, counts sixteen edges from the start write, and places a write of zero to the flag and start bits on that edge. It then reads the flag back. The abort case and the external-clock case are also driven on purpose: the abort comes partway through a slow transfer, and the external case holds the clock pin still for a while before it toggles, so that the port is seen waiting.

// File: rtl/sio8_pkg.sv
package sio8_pkg;

  typedef enum logic [1:0] {
    CK_FAST = 2'b00,
    CK_MID  = 2'b01,
    CK_SLOW = 2'b10,
    CK_EXT  = 2'b11
  } cksel_e;

  localparam int MB_GO   = 0;
  localparam int MB_DONE = 1;
  localparam int MB_IE   = 2;
  localparam int MB_SEL  = 3;
  localparam int MB_MSB  = 5;
  localparam int MB_CKOE = 6;
  localparam int MB_DOE  = 7;

endpackage

// File: rtl/sio8_clkgen.sv
module sio8_clkgen
  import sio8_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   restart,
  input  cksel_e sel,
  input  logic   sck_in,
  output logic   sck_int,
  output logic   fall,
  output logic   rise
);

  localparam int HA = DIV_A / 2;
  localparam int HB = DIV_B / 2;
  localparam int HC = DIV_C / 2;
  localparam int CW = $clog2(HC + 1);

  logic [CW-1:0] cnt_q, cnt_d, half_m1;
  logic          sck_q, sck_d;
  logic [2:0]    sync_q, sync_d;
  logic          internal, tick, ext_fall, ext_rise;

  always_comb begin
    case (sel)
      CK_FAST: half_m1 = CW'(HA - 1);
      CK_MID:  half_m1 = CW'(HB - 1);
      default: half_m1 = CW'(HC - 1);
    endcase
  end

  assign internal = (sel != CK_EXT);
  assign tick     = run & internal & (cnt_q == half_m1);
  assign ext_fall = run & ~internal & ~sync_q[1] &  sync_q[2];
  assign ext_rise = run & ~internal &  sync_q[1] & ~sync_q[2];

  always_comb begin
    cnt_d  = cnt_q;
    sck_d  = sck_q;
    sync_d = {sync_q[1:0], sck_in};
    if (restart || !run || !internal) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      sync_q <= sync_d;
    end
  end

  assign sck_int = sck_q;
  assign fall    = (tick & sck_q) | ext_fall;
  assign rise    = (tick & ~sck_q) | ext_rise;

endmodule

// File: rtl/sio8_shifter.sv
module sio8_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         start,
  input  logic         stop,
  input  logic         fall,
  input  logic         rise,
  input  logic         sdi,
  output logic [W-1:0] sr,
  output logic         sdo,
  output logic         busy,
  output logic         done
);

  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr_q, sr_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          sdo_q, sdo_d;
  logic          shift_en;

  assign shift_en = busy_q & rise;
  assign done     = shift_en & (cnt_q == BW'(W - 1));

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    sdo_d  = sdo_q;
    if (load)
      sr_d = load_val;
    else if (shift_en)
      sr_d = {sdi, sr_q[W-1:1]};
    if (start)
      cnt_d = '0;
    else if (shift_en)
      cnt_d = cnt_q + 1'b1;
    if (start)
      busy_d = 1'b1;
    else if (stop || done)
      busy_d = 1'b0;
    if (busy_q && fall)
      sdo_d = sr_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sdo_q  <= 1'b1;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      sdo_q  <= sdo_d;
    end
  end

  assign sr   = sr_q;
  assign sdo  = sdo_q;
  assign busy = busy_q;

endmodule

// File: rtl/sio8_port.sv
module sio8_port
  import sio8_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         sck_in,
  output logic         sck_out,
  output logic         sck_oe,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_en,
  output logic         irq
);

  logic   wr_mode, wr_data, go_w, stop_w;
  logic   flag_q, flag_d, ie_q, ie_d, msb_q, msb_d, ckoe_q, ckoe_d, doe_q, doe_d;
  cksel_e sel_q, sel_d;
  logic   busy_q, done, fall, rise;
  logic [W-1:0] sr, ld_val, sr_view;
  logic [7:0]   mode_rd;

  assign wr_mode = bus_wr & ~bus_addr;
  assign wr_data = bus_wr &  bus_addr;
  assign go_w    = wr_mode &  bus_wdata[MB_GO];
  assign stop_w  = wr_mode & ~bus_wdata[MB_GO];

  always_comb begin
    ie_d   = ie_q;
    sel_d  = sel_q;
    msb_d  = msb_q;
    ckoe_d = ckoe_q;
    doe_d  = doe_q;
    flag_d = flag_q;
    if (wr_mode) begin
      ie_d   = bus_wdata[MB_IE];
      sel_d  = cksel_e'(bus_wdata[MB_SEL+1:MB_SEL]);
      msb_d  = bus_wdata[MB_MSB];
      ckoe_d = bus_wdata[MB_CKOE];
      doe_d  = bus_wdata[MB_DOE];
      if (!bus_wdata[MB_DONE])
        flag_d = 1'b0;
    end
    if (done)
      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      sel_q  <= CK_FAST;
      msb_q  <= 1'b0;
      ckoe_q <= 1'b0;
      doe_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      sel_q  <= sel_d;
      msb_q  <= msb_d;
      ckoe_q <= ckoe_d;
      doe_q  <= doe_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      ld_val[i]  = msb_q ? bus_wdata[W-1-i] : bus_wdata[i];
      sr_view[i] = msb_q ? sr[W-1-i] : sr[i];
    end
  end

  sio8_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_q),
    .restart (go_w),
    .sel     (sel_q),
    .sck_in  (sck_in),
    .sck_int (sck_out),
    .fall    (fall),
    .rise    (rise)
  );

  sio8_shifter #(.W(W)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_data),
    .load_val (ld_val),
    .start    (go_w),
    .stop     (stop_w),
    .fall     (fall),
    .rise     (rise),
    .sdi      (sdi),
    .sr       (sr),
    .sdo      (sdo),
    .busy     (busy_q),
    .done     (done)
  );

  assign mode_rd   = {doe_q, ckoe_q, msb_q, sel_q, ie_q, flag_q, busy_q};
  assign bus_rdata = bus_addr ? sr_view : W'(mode_rd);
  assign sck_oe    = ckoe_q & (sel_q != CK_EXT);
  assign sdo_en    = doe_q;
  assign irq       = flag_q & ie_q;

endmodule

// File: rtl/sio8_port_chk.sv
module sio8_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       flag,
  input logic       done,
  input logic       fall,
  input logic       sck_out,
  input logic       sck_oe,
  input logic [1:0] sel,
  input logic       sdo,
  input logic       wr,
  input logic       addr,
  input logic       go_bit
);

  // R11: completion always leaves the flag set
  p_flag_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  // R1: completion drops busy unless a new start coincides
  p_done_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(wr && !addr && go_bit)) |=> !busy);

  // R4: idle internal clock rests high
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> sck_out);

  // R5: external source never drives the pin
  p_ext_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !sck_oe);

  // R6: data out moves only on a falling shift edge
  p_sdo_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo));

  // R10: writing start = 0 leaves the port idle
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && !go_bit) |=> !busy);

endmodule

bind sio8_port sio8_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_q),
  .flag    (flag_q),
  .done    (done),
  .fall    (fall),
  .sck_out (sck_out),
  .sck_oe  (sck_oe),
  .sel     (sel_q),
  .sdo     (sdo),
  .wr      (bus_wr),
  .addr    (bus_addr),
  .go_bit  (bus_wdata[0])
);

// File: tb/tb_sio8_port.sv
`timescale 1ns/1ps
module tb_sio8_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe, sdi, sdo, sdo_en, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sio8_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .sdo_en(sdo_en), .irq(irq)
  );

  // serial input pattern
  logic [15:0] lfsr = 16'hACE1;
  assign sdi = lfsr[0];
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  end

  // behavioural reference
  bit m_busy, m_flag, m_ie, m_msb, m_ckoe, m_doe, m_sck, m_sdo, m_valid;
  int m_sel, m_cnt, m_bits;
  bit m_wire[8];
  bit txq[$];
  bit rxq[$];
  bit s1, s2, s3;

  function automatic logic [7:0] m_mode();
    return {m_doe, m_ckoe, m_msb, 2'(m_sel), m_ie, m_flag, m_busy};
  endfunction

  function automatic logic [7:0] m_data();
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[j] = m_msb ? m_wire[7-j] : m_wire[j];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_flag = 0; m_ie = 0; m_msb = 0; m_ckoe = 0; m_doe = 0;
      m_sel = 0; m_sck = 1; m_sdo = 1; m_cnt = 0; m_bits = 0; m_valid = 1;
      for (int i = 0; i < 8; i++) m_wire[i] = 0;
      txq = {}; rxq = {}; s1 = 1; s2 = 1; s3 = 1;
    end else begin
      int half;
      bit fl, rs, dn;
      half = (m_sel == 0) ? 1 : (m_sel == 1) ? 4 : 16;
      fl = 0; rs = 0; dn = 0;
      if (!m_busy || m_sel == 3) begin
        if (m_busy) begin
          fl = !s2 && s3;
          rs = s2 && !s3;
        end
        m_cnt = 0; m_sck = 1;
      end else begin
        m_cnt++;
        if (m_cnt == half) begin
          m_cnt = 0; m_sck = !m_sck;
          if (m_sck) rs = 1; else fl = 1;
        end
      end
      s3 = s2; s2 = s1; s1 = sck_in;
      if (fl && txq.size() > 0) m_sdo = txq.pop_front();
      if (rs) begin
        rxq.push_back(sdi);
        m_bits++;
        if (m_bits == 8) begin
          dn = 1; m_busy = 0; m_flag = 1; m_valid = 1;
          for (int i = 0; i < 8; i++) m_wire[i] = rxq[i];
        end
      end
      if (bus_wr && !bus_addr) begin
        m_ie = bus_wdata[2]; m_sel = int'(bus_wdata[4:3]);
        m_msb = bus_wdata[5]; m_ckoe = bus_wdata[6]; m_doe = bus_wdata[7];
        if (!bus_wdata[1] && !dn) m_flag = 0;
        if (bus_wdata[0]) begin
          m_busy = 1; m_cnt = 0; m_sck = 1; m_bits = 0;
          txq = {}; rxq = {};
          for (int i = 0; i < 8; i++) txq.push_back(m_wire[i]);
        end else begin
          if (m_busy) m_valid = 0;
          m_busy = 0;
        end
      end
      if (bus_wr && bus_addr) begin
        for (int i = 0; i < 8; i++) m_wire[i] = m_msb ? bus_wdata[7-i] : bus_wdata[i];
        m_valid = 1;
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 sck_out", {7'b0, sck_out}, {7'b0, m_sck});
      chk("R6 sdo", {7'b0, sdo}, {7'b0, m_sdo});
      chk("R6 sdo_en", {7'b0, sdo_en}, {7'b0, m_doe});
      chk("R3 irq", {7'b0, irq}, {7'b0, m_flag & m_ie});
      chk("R5 sck_oe", {7'b0, sck_oe}, {7'b0, m_ckoe && (m_sel != 3)});
      if (!bus_addr)
        chk("R1 mode read", bus_rdata, m_mode());
      else if (m_valid && !m_busy)
        chk("R7 data read", bus_rdata, m_data());
    end
  end

  function automatic logic [7:0] mk(bit go, bit fw, bit ie, int sel, bit msb, bit ckoe, bit doe);
    return {doe, ckoe, msb, 2'(sel), ie, fw, go};
  endfunction

  task automatic wr_reg(bit a, logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && m_busy; i++) @(posedge clk);
    @(posedge clk); #1;
  endtask

  task automatic peek(bit a, int cycles);
    @(posedge clk); #1; bus_addr = a;
    repeat (cycles) @(posedge clk);
    #1; bus_addr = 0;
  endtask

  task automatic at_neg_chk(string req, logic [7:0] act_sel, logic [7:0] exp);
    chk(req, act_sel, exp);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R12 reset mode", bus_rdata, 8'h00);
    chk("R12 reset sck_out", {7'b0, sck_out}, 8'h01);
    chk("R12 reset sdo", {7'b0, sdo}, 8'h01);
    chk("R12 reset irq", {7'b0, irq}, 8'h00);
    peek(1, 2);
    @(negedge clk); #0;

    // R1 R4 R6 R8: fastest rate, LSB first
    wr_reg(1, 8'hA5);
    wr_reg(0, mk(1, 1, 1, 0, 0, 1, 1));
    wait_idle();
    @(negedge clk);
    chk("R1 flag set busy clear", bus_rdata & 8'h03, 8'h02);
    peek(1, 3);

    // R2: writing 1 to flag keeps it, writing 0 clears it
    wr_reg(0, mk(0, 1, 1, 0, 0, 1, 1));
    @(negedge clk);
    chk("R2 flag kept by write one", {7'b0, irq}, 8'h01);
    wr_reg(0, mk(0, 0, 1, 0, 0, 1, 1));
    @(negedge clk);
    chk("R2 flag cleared by write zero", {7'b0, irq}, 8'h00);

    // R7 R8: middle rate, MSB first
    wr_reg(0, mk(0, 0, 1, 1, 1, 1, 1));
    wr_reg(1, 8'h3C);
    peek(1, 2);
    wr_reg(0, mk(1, 0, 1, 1, 1, 1, 1));
    wait_idle();
    peek(1, 3);

    // R7: order change after load does not reorder the loaded byte
    wr_reg(0, mk(0, 0, 0, 2, 0, 0, 1));
    wr_reg(1, 8'h1E);
    wr_reg(0, mk(0, 0, 0, 2, 1, 0, 1));
    peek(1, 2);
    wr_reg(0, mk(1, 0, 0, 2, 1, 0, 1));
    wait_idle();
    peek(1, 3);

    // R9 R5: external clock, pin drive requested but not granted
    wr_reg(1, 8'hD2);
    wr_reg(0, mk(1, 0, 1, 3, 0, 1, 1));
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R9 waits for external edges", bus_rdata & 8'h01, 8'h01);
    chk("R5 no drive with external clock", {7'b0, sck_oe}, 8'h00);
    for (int b = 0; b < 8; b++) begin
      @(posedge clk); #1 sck_in = 0;
      repeat (4) @(posedge clk);
      #1 sck_in = 1;
      repeat (4) @(posedge clk);
    end
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R9 external transfer complete", bus_rdata & 8'h03, 8'h02);
    peek(1, 3);
    wr_reg(0, mk(0, 0, 0, 0, 0, 0, 1));

    // R10: abort partway through
    wr_reg(1, 8'h55);
    wr_reg(0, mk(1, 0, 1, 1, 0, 1, 1));
    repeat (20) @(posedge clk);
    wr_reg(0, mk(0, 0, 1, 1, 0, 1, 1));
    @(negedge clk);
    chk("R10 abort busy clear", bus_rdata & 8'h03, 8'h00);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R10 abort sck_out idle", {7'b0, sck_out}, 8'h01);
    chk("R10 abort flag clear", {7'b0, irq}, 8'h00);

    // R11: flag clear on the completion edge
    wr_reg(1, 8'h0F);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = 0; bus_wdata = mk(1, 0, 1, 0, 0, 1, 1);
    @(posedge clk); #1;
    bus_wr = 0;
    repeat (15) @(posedge clk);
    #1;
    bus_wr = 1; bus_addr = 0; bus_wdata = mk(0, 0, 1, 0, 0, 1, 1);
    @(posedge clk); #1;
    bus_wr = 0;
    @(negedge clk);
    chk("R11 hardware set wins", bus_rdata & 8'h03, 8'h02);
    chk("R11 irq raised", {7'b0, irq}, 8'h01);
    peek(1, 3);

    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_up();
  end

endmodule